// File: doc/BRIEF.md
# IPv4 Header Checker and TTL Rewriter

This block sits in a packet-forwarding datapath and screens one 20-byte IPv4 header (no options) per transfer. The header arrives as five 32-bit big-endian words. The block checks the version, header length, total length, time-to-live and header checksum. If every check passes, it lowers the TTL by one and repairs the stored checksum incrementally. It does not recompute the checksum from scratch. It returns the rewritten third header word and a keep flag. A cleared keep flag asks downstream logic to drop the packet.

Both sides use a valid/ready handshake. A header is taken on a clock edge where `in_valid` and `in_ready` are both high. A result leaves on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, a presented result stays on the outputs unchanged. The block holds at most two headers in flight, one per pipeline register. When both registers are full and the output is stalled, `in_ready` falls. Results leave in the order their headers were accepted.

Top module: `ipv4_ttl_rewriter`

## Requirements
- R1: The version field is bits 31:28 of word 0. A value other than 4 clears `out_keep`.
- R2: The header length field is bits 27:24 of word 0 and counts 32-bit words. A value below 5 clears `out_keep`.
- R3: The total length is bits 15:0 of word 0. Unless it is strictly greater than four times the header length field, `out_keep` is cleared.
- R4: The checksum test adds the ten 16-bit halves of the five words as a one's-complement sum, folding carries back in. Unless the result is 0xFFFF, `out_keep` is cleared.
- R5: The TTL is bits 31:24 of word 2. A TTL of zero clears `out_keep`. For a kept header, the output TTL is the input TTL minus one, so a TTL of 1 leaves as 0.
- R6: For a kept header, bits 15:0 of `out_word2` hold the stored checksum plus 0x0100, with any carry out of bit 15 added back in. Bits 23:16 (protocol) are copied unchanged. The rewritten header therefore passes the R4 test.
- R7: When any check fails, `out_keep` is 0 and `out_word2` equals the input word 2 bit for bit.
- R8: With `out_ready` high, a header accepted on clock edge k has its result on the outputs after edge k+1 and not after edge k. Each accepted header yields exactly one result.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_word2` and `out_keep` hold steady. With two headers held and the output stalled, `in_ready` is low. Results leave in acceptance order.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A header is offered on the word inputs |
| in_ready | output | 1 | The block can take a header this cycle |
| in_w0 | input | 32 | Header word 0: version, header length, service type, total length |
| in_w1 | input | 32 | Header word 1: identification, flags, fragment offset |
| in_w2 | input | 32 | Header word 2: TTL, protocol, checksum |
| in_w3 | input | 32 | Header word 3: source address |
| in_w4 | input | 32 | Header word 4: destination address |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_word2 | output | 32 | Rewritten word 2 if kept, otherwise the original word 2 |
| out_keep | output | 1 | 1 = forward the packet, 0 = drop it |

## Verification
The assertions rely on the upstream side following the handshake. They also rely on `rst_n` being asserted before the first result is inspected. The hold checks on the output compare each cycle with the one before, so a stall is only meaningful after reset has cleared the pipeline. The stimulus changes the word inputs only at falling edges. It raises `in_valid` only for headers it expects to be accepted, so the pipeline never sees a half-updated header. Headers built for the keep path get a correct checksum from the bench. Their addresses are steered so that the stored checksum is never 0xFEFF, since incremental and full recomputation would disagree there on the sign of zero.

// File: rtl/ipv4_hdr_pkg.sv
package ipv4_hdr_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned HALF_W     = 16;
  localparam logic [3:0]  V4_CODE    = 4'd4;
  localparam logic [3:0]  IHL_FLOOR  = 4'd5;
  localparam logic [15:0] TTL_WEIGHT = 16'h0100;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic  keep;
    word_t w2;
  } verdict_t;
endpackage

// File: rtl/hs_reg_stage.sv
module hs_reg_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (up_ready) begin
      full_q <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_ready) begin
      data_q <= up_data;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data)); // R9
endmodule

// File: rtl/ipv4_csum_fold.sv
module ipv4_csum_fold #(
  parameter int unsigned NUM_WORDS = 5
) (
  input  logic [NUM_WORDS*32-1:0] hdr,
  output logic [15:0]             folded,
  output logic                    sum_ok
);
  localparam int unsigned HALVES = 2 * NUM_WORDS;
  localparam int unsigned ACC_W  = 16 + $clog2(HALVES) + 1;

  logic [ACC_W-1:0] acc;
  logic [16:0]      fold1;

  always_comb begin
    acc = '0;
    for (int h = 0; h < HALVES; h++) begin
      acc = acc + ACC_W'(hdr[h*16 +: 16]);
    end
    fold1  = 17'(acc[15:0]) + 17'(acc[ACC_W-1:16]);
    folded = fold1[15:0] + 16'(fold1[16]);
    sum_ok = (folded == 16'hFFFF);
  end
endmodule

// File: rtl/ipv4_field_rules.sv
module ipv4_field_rules
  import ipv4_hdr_pkg::*;
(
  input  word_t w0,
  input  word_t w2,
  input  logic  csum_ok,
  output logic  keep
);
  logic [3:0]  ver;
  logic [3:0]  ihl;
  logic [15:0] tot_len;
  logic [17:0] hdr_bytes;
  logic        ver_ok, ihl_ok, len_ok, ttl_ok;

  always_comb begin
    ver       = w0[31:28];
    ihl       = w0[27:24];
    tot_len   = w0[15:0];
    hdr_bytes = {12'd0, ihl, 2'b00};
    ver_ok    = (ver == V4_CODE);
    ihl_ok    = (ihl >= IHL_FLOOR);
    len_ok    = ({2'b00, tot_len} > hdr_bytes);
    ttl_ok    = (w2[31:24] != 8'd0);
    keep      = ver_ok && ihl_ok && len_ok && ttl_ok && csum_ok;
  end
endmodule

// File: rtl/ipv4_ttl_patch.sv
module ipv4_ttl_patch
  import ipv4_hdr_pkg::*;
(
  input  word_t w2_in,
  output word_t w2_out
);
  logic [16:0] raw;
  logic [15:0] fixed;

  always_comb begin
    raw    = 17'(w2_in[15:0]) + 17'(TTL_WEIGHT);
    fixed  = raw[15:0] + 16'(raw[16]);
    w2_out = {w2_in[31:24] - 8'd1, w2_in[23:16], fixed};
  end
endmodule

// File: rtl/ipv4_ttl_rewriter.sv
module ipv4_ttl_rewriter
  import ipv4_hdr_pkg::*;
#(
  parameter int unsigned HDR_WORDS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_w0,
  input  logic [31:0] in_w1,
  input  logic [31:0] in_w2,
  input  logic [31:0] in_w3,
  input  logic [31:0] in_w4,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_word2,
  output logic        out_keep
);
  localparam int unsigned HDR_W = HDR_WORDS * WORD_W;
  localparam int unsigned VER_W = $bits(verdict_t);

  logic [HDR_W-1:0] hdr_in, hdr_q;
  logic             s1_valid, s1_ready;
  word_t            s1_w0, s1_w2, patched;
  logic [15:0]      folded;
  logic             csum_ok, keep_c;
  verdict_t         verdict_c, verdict_q;

  assign hdr_in = {in_w0, in_w1, in_w2, in_w3, in_w4};

  hs_reg_stage #(.DATA_W(HDR_W)) u_hdr_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(hdr_in),
    .dn_valid(s1_valid), .dn_ready(s1_ready), .dn_data(hdr_q)
  );

  assign s1_w0 = hdr_q[HDR_W-1 -: WORD_W];
  assign s1_w2 = hdr_q[HDR_W-1-2*WORD_W -: WORD_W];

  ipv4_csum_fold #(.NUM_WORDS(HDR_WORDS)) u_csum (
    .hdr(hdr_q), .folded(folded), .sum_ok(csum_ok)
  );

  ipv4_field_rules u_rules (
    .w0(s1_w0), .w2(s1_w2), .csum_ok(csum_ok), .keep(keep_c)
  );

  ipv4_ttl_patch u_patch (
    .w2_in(s1_w2), .w2_out(patched)
  );

  always_comb begin
    verdict_c.keep = keep_c;
    verdict_c.w2   = keep_c ? patched : s1_w2;
  end

  hs_reg_stage #(.DATA_W(VER_W)) u_out_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(s1_valid), .up_ready(s1_ready), .up_data(verdict_c),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(verdict_q)
  );

  assign out_word2 = verdict_q.w2;
  assign out_keep  = verdict_q.keep;

  logic load_out;
  assign load_out = s1_valid && s1_ready;

  AST_DROP_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    load_out |=> (out_keep || out_word2 == $past(s1_w2))); // R7
  AST_TTL_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    load_out |=> (!out_keep || out_word2[31:24] == $past(s1_w2[31:24]) - 8'd1)); // R5
  AST_PROTO_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    load_out |=> (out_word2[23:16] == $past(s1_w2[23:16]))); // R6
  AST_KEEP_NEEDS_V4: assert property (@(posedge clk) disable iff (!rst_n)
    load_out |=> (!out_keep || $past(s1_w0[31:28]) == V4_CODE)); // R1
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && out_valid && !out_ready |-> !in_ready); // R9
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && out_ready |=> s1_valid); // R8
endmodule

// File: tb/ipv4_ttl_rewriter_test.sv
module ipv4_ttl_rewriter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_w0 = '0, in_w1 = '0, in_w2 = '0, in_w3 = '0, in_w4 = '0;
  logic        in_ready, out_valid, out_keep;
  logic [31:0] out_word2;
  int          checks = 0, failures = 0;
  bit          done = 0;
  logic [31:0] hw [5];

  always #10 clk = ~clk;

  ipv4_ttl_rewriter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_w0(in_w0), .in_w1(in_w1), .in_w2(in_w2), .in_w3(in_w3), .in_w4(in_w4),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_word2(out_word2), .out_keep(out_keep)
  );

  function automatic logic [15:0] ones_sum(logic [31:0] a, b, c, d, e);
    logic [31:0] s;
    s = 32'(a[31:16]) + a[15:0] + b[31:16] + b[15:0] + c[31:16] + c[15:0]
      + d[31:16] + d[15:0] + e[31:16] + e[15:0];
    s = 32'(s[15:0]) + 32'(s[31:16]);
    s = 32'(s[15:0]) + 32'(s[31:16]);
    return s[15:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // builds a header with a correct checksum; dst low half is free for steering
  task automatic build(logic [3:0] ver, logic [3:0] ihl, logic [15:0] tlen,
                       logic [7:0] ttl, logic [7:0] proto, logic [15:0] dlo);
    hw[0] = {ver, ihl, 8'h00, tlen};
    hw[1] = 32'h1c46_4000;
    hw[2] = {ttl, proto, 16'h0000};
    hw[3] = 32'hc0a8_0001;
    hw[4] = {16'hc0a8, dlo};
    hw[2][15:0] = ~ones_sum(hw[0], hw[1], hw[2], hw[3], hw[4]);
  endtask

  function automatic logic [31:0] rewritten();
    logic [31:0] n;
    n = {hw[2][31:24] - 8'd1, hw[2][23:16], 16'h0000};
    n[15:0] = ~ones_sum(hw[0], hw[1], n, hw[3], hw[4]);
    return n;
  endfunction

  task automatic offer();
    @(negedge clk);
    in_w0 = hw[0]; in_w1 = hw[1]; in_w2 = hw[2]; in_w3 = hw[3]; in_w4 = hw[4];
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // one header with the output free; checks latency, keep and word 2
  task automatic run_one(string req, logic exp_keep);
    logic [31:0] exp_w2;
    exp_w2 = exp_keep ? rewritten() : hw[2];
    out_ready = 1'b1;
    offer();
    check({req, "/R8 early"}, 32'(out_valid), 32'd0);
    @(negedge clk);
    check({req, "/R8 valid"}, 32'(out_valid), 32'd1);
    check({req, " keep"}, 32'(out_keep), 32'(exp_keep));
    check({req, " word2"}, out_word2, exp_w2);
    if (exp_keep)
      check({req, "/R6 verify"},
            32'(ones_sum(hw[0], hw[1], out_word2, hw[3], hw[4])), 32'h0000FFFF);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 out_valid", 32'(out_valid), 32'd0);
    check("R10 in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_good();
    build(4'd4, 4'd5, 16'd60, 8'd64, 8'h06, 16'h0a0b);
    run_one("R5 normal", 1'b1);
    build(4'd4, 4'd5, 16'd1500, 8'd200, 8'h11, 16'h7777);
    run_one("R6 udp", 1'b1);
  endtask

  task automatic t_ttl();
    build(4'd4, 4'd5, 16'd40, 8'd1, 8'h01, 16'h1234);
    run_one("R5 ttl1", 1'b1);
    build(4'd4, 4'd5, 16'd40, 8'd0, 8'h01, 16'h1234);
    run_one("R5 ttl0", 1'b0);
  endtask

  task automatic t_fields();
    build(4'd6, 4'd5, 16'd40, 8'd9, 8'h06, 16'h0001);
    run_one("R1 ver6", 1'b0);
    build(4'd4, 4'd4, 16'd40, 8'd9, 8'h06, 16'h0002);
    run_one("R2 ihl4", 1'b0);
    build(4'd4, 4'd5, 16'd20, 8'd9, 8'h06, 16'h0003);
    run_one("R3 len20", 1'b0);
    build(4'd4, 4'd5, 16'd21, 8'd9, 8'h06, 16'h0004);
    run_one("R3 len21", 1'b1);
    build(4'd4, 4'd6, 16'd24, 8'd9, 8'h06, 16'h0005);
    run_one("R3 ihl6 len24", 1'b0);
  endtask

  task automatic t_bad_sum();
    build(4'd4, 4'd5, 16'd40, 8'd9, 8'h06, 16'h0042);
    hw[2][15:0] = hw[2][15:0] ^ 16'h0010;
    run_one("R4 badsum", 1'b0);
  endtask

  task automatic t_carry();
    logic [15:0] a;
    build(4'd4, 4'd5, 16'd40, 8'd9, 8'h06, 16'h0000);
    a = ones_sum(hw[0], hw[1], {hw[2][31:16], 16'h0}, hw[3], hw[4]);
    hw[4][15:0] = ones_sum(32'h0001, 32'(~a), 32'h0, 32'h0, 32'h0);
    hw[2][15:0] = ~ones_sum(hw[0], hw[1], {hw[2][31:16], 16'h0}, hw[3], hw[4]);
    check("R6 carry setup", 32'(hw[2][15:0]), 32'h0000FFFE);
    run_one("R6 carry", 1'b1);
  endtask

  task automatic t_stall();
    logic [31:0] wa, wb;
    out_ready = 1'b0;
    build(4'd4, 4'd5, 16'd80, 8'd30, 8'h06, 16'h1111);
    wa = rewritten();
    offer();
    build(4'd4, 4'd5, 16'd90, 8'd0, 8'h06, 16'h2222);
    wb = hw[2];
    offer();
    check("R9 full", 32'(in_ready), 32'd0);
    check("R9 first out", out_word2, wa);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 hold valid", 32'(out_valid), 32'd1);
      check("R9 hold word", out_word2, wa);
      check("R9 hold keep", 32'(out_keep), 32'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 order valid", 32'(out_valid), 32'd1);
    check("R9 order word", out_word2, wb);
    check("R7 drop keep", 32'(out_keep), 32'd0);
    @(negedge clk);
    check("R8 drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_ttl();
    t_fields();
    t_bad_sum();
    t_carry();
    t_stall();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule